// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two data buses, side A and side B, and moves a word from one to the other. The word can come live from the far bus or from a stored copy. Each side has its own capture register. The A register loads from the A bus when the A strobe rises, and the B register loads from the B bus when the B strobe rises. The two strobes are independent level inputs. Both are sampled in the single system clock domain, so a register loads on the system edge at which its strobe is first seen high after being low.

An active-low enable and a direction input decide which bus, if any, the block drives. There are two select inputs. One picks live or stored data for the word sent towards B, and the other does the same for the word sent towards A. The pads are not part of this block. Each side therefore has a separate input vector, an output vector and a one-bit output enable, and the surrounding logic combines them into a tri-state pad.

Capture is independent of the output mode. A register keeps loading while the outputs are isolated, and it also loads while its bus is acting as the receiving input. This lets a word be parked during isolation and driven onto the other bus later.

Top module: `xcvr_reg_top`

## Requirements
- R1: On the system clock edge where `a_stb_i` is first sampled high after being sampled low, the A register loads `a_i`.
- R2: On the system clock edge where `b_stb_i` is first sampled high after being sampled low, the B register loads `b_i`.
- R3: A register whose strobe stays high, or stays low, keeps its contents regardless of its bus input.
- R4: With `oe_ni` high, both `a_oe_o` and `b_oe_o` are 0, and both registers still load on their strobe edges.
- R5: With `oe_ni` low and `dir_i` 0, `a_oe_o` is 1 and `b_oe_o` is 0.
- R6: With `oe_ni` low and `dir_i` 1, `b_oe_o` is 1 and `a_oe_o` is 0.
- R7: `b_o` equals `a_i` when `sel_ab_i` is 0 and equals the A register when `sel_ab_i` is 1, whatever the enables are.
- R8: `a_o` equals `b_i` when `sel_ba_i` is 0 and equals the B register when `sel_ba_i` is 1, whatever the enables are.
- R9: `a_oe_o` and `b_oe_o` are never 1 at the same time.
- R10: When both strobes rise on the same system clock edge, both registers load on that edge.
- R11: While `rst_ni` is low, both enables are 0 and both registers are cleared to zero. The registers stay zero after reset until a strobe edge.
- R12: A change on a select input or on a live bus input reaches the outputs in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_stb_i | input | 1 | A capture strobe, loads on its rising edge |
| b_stb_i | input | 1 | B capture strobe, loads on its rising edge |
| oe_ni | input | 1 | Output enable, active low |
| dir_i | input | 1 | 1 drives B from the A path, 0 drives A from the B path |
| sel_ab_i | input | 1 | Source for B: 0 live A, 1 stored A |
| sel_ba_i | input | 1 | Source for A: 0 live B, 1 stored B |
| a_i | input | DATA_W | Value sampled from the A bus |
| b_i | input | DATA_W | Value sampled from the B bus |
| a_o | output | DATA_W | Value to drive onto the A bus |
| a_oe_o | output | 1 | Drive enable for the A bus |
| b_o | output | DATA_W | Value to drive onto the B bus |
| b_oe_o | output | 1 | Drive enable for the B bus |

## Verification
A register that loads wrongly, misses a strobe edge or loads twice stays hidden until its select picks stored data. On the first cycle after that, the wrong word appears on `b_o` or `a_o`. For this reason every store in the bench is followed by a stored-path read, so a bad register value shows up one cycle after the edge that should have set it. A fault in the enable decode is visible at once on the enable outputs, and two enables high together would mean two drivers on one bus.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned NUM_SIDES = 2;
  localparam int unsigned SIDE_A    = 0;
  localparam int unsigned SIDE_B    = 1;

  typedef enum logic [1:0] {
    DRV_NONE = 2'b00,
    DRV_A    = 2'b01,
    DRV_B    = 2'b10
  } drive_e;
endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (cap_i) q_o <= d_i;
  end

  // R1, R2, R10
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> q_o == $past(d_i));

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(q_o));
endmodule

// File: rtl/xcvr_drive_dec.sv
module xcvr_drive_dec
  import xcvr_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   oe_ni,
  input  logic   dir_i,
  output drive_e drive_o
);
  always_comb begin
    drive_o = DRV_NONE;
    if (rst_ni && !oe_ni) drive_o = dir_i ? DRV_B : DRV_A;
  end

  // R4
  isolate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> drive_o == DRV_NONE);

  // R9
  single_drv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(drive_o));
endmodule

// File: rtl/xcvr_reg_top.sv
module xcvr_reg_top
  import xcvr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_stb_i,
  input  logic              b_stb_i,
  input  logic              oe_ni,
  input  logic              dir_i,
  input  logic              sel_ab_i,
  input  logic              sel_ba_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] a_o,
  output logic              a_oe_o,
  output logic [DATA_W-1:0] b_o,
  output logic              b_oe_o
);
  localparam int unsigned NS = NUM_SIDES;

  logic [NS-1:0]             stb;
  logic [NS-1:0]             rise;
  logic [NS-1:0][DATA_W-1:0] cap_d;
  logic [NS-1:0][DATA_W-1:0] cap_q;
  drive_e                    drive;

  assign stb[SIDE_A]   = a_stb_i;
  assign stb[SIDE_B]   = b_stb_i;
  assign cap_d[SIDE_A] = a_i;
  assign cap_d[SIDE_B] = b_i;

  xcvr_edge_det #(.N(NS)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (stb),
    .rise_o (rise)
  );

  for (genvar s = 0; s < NS; s++) begin : g_cap
    xcvr_cap_reg #(.W(DATA_W)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cap_i  (rise[s]),
      .d_i    (cap_d[s]),
      .q_o    (cap_q[s])
    );
  end

  xcvr_drive_dec u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .oe_ni   (oe_ni),
    .dir_i   (dir_i),
    .drive_o (drive)
  );

  // live or stored word per direction
  assign b_o    = sel_ab_i ? cap_q[SIDE_A] : a_i;
  assign a_o    = sel_ba_i ? cap_q[SIDE_B] : b_i;
  assign a_oe_o = (drive == DRV_A);
  assign b_oe_o = (drive == DRV_B);

  // R7
  stored_ab_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ab_i && $past(rise[SIDE_A]) && !rise[SIDE_A] |-> b_o == $past(a_i));

  // R8
  stored_ba_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ba_i && $past(rise[SIDE_B]) && !rise[SIDE_B] |-> a_o == $past(b_i));

  // R5, R6
  dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_ni |-> (b_oe_o == dir_i) && (a_oe_o == !dir_i));
endmodule

// File: tb/sim_xcvr_reg_top.sv
`timescale 1ns/1ps
module sim_xcvr_reg_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         a_stb = 1'b0, b_stb = 1'b0, oe_n = 1'b1, dir = 1'b0;
  logic         s_ab = 1'b0, s_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;

  int errors = 0;
  int checks = 0;
  logic [W-1:0] ref_a = '0, ref_b = '0;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         aoe;
    logic         boe;
    string        req;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  xcvr_reg_top #(.DATA_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .a_stb_i(a_stb), .b_stb_i(b_stb),
    .oe_ni(oe_n), .dir_i(dir), .sel_ab_i(s_ab), .sel_ba_i(s_ba),
    .a_i(a_in), .b_i(b_in), .a_o(a_out), .a_oe_o(a_oe),
    .b_o(b_out), .b_oe_o(b_oe)
  );

  // monitor
  initial begin
    forever begin
      exp_t e;
      wait (sb_q.size() > 0);
      e = sb_q.pop_front();
      checks++;
      if (a_out !== e.a || b_out !== e.b || a_oe !== e.aoe || b_oe !== e.boe) begin
        errors++;
        $display("FAIL %s: a_o=%h b_o=%h a_oe=%b b_oe=%b expected a_o=%h b_o=%h a_oe=%b b_oe=%b",
                 e.req, a_out, b_out, a_oe, b_oe, e.a, e.b, e.aoe, e.boe);
      end
    end
  end

  // driver side: expected values from the requirements
  task automatic expect_now(input string req);
    exp_t e;
    e.aoe = rst_n && !oe_n && !dir;
    e.boe = rst_n && !oe_n && dir;
    e.b   = s_ab ? ref_a : a_in;
    e.a   = s_ba ? ref_b : b_in;
    e.req = req;
    sb_q.push_back(e);
    #1;
  endtask

  task automatic set_mode(input logic oe, input logic d, input logic sa, input logic sb_);
    @(negedge clk);
    oe_n = oe; dir = d; s_ab = sa; s_ba = sb_;
  endtask

  // raise chosen strobes with data, hold one cycle, lower
  task automatic store(input logic do_a, input logic do_b,
                       input logic [W-1:0] da, input logic [W-1:0] db);
    @(negedge clk);
    if (do_a) begin a_in = da; a_stb = 1'b1; end
    if (do_b) begin b_in = db; b_stb = 1'b1; end
    @(posedge clk);
    if (do_a) ref_a = da;
    if (do_b) ref_b = db;
    @(negedge clk);
    a_stb = 1'b0; b_stb = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R11: enables low in reset even when requested
    oe_n = 1'b0; dir = 1'b1;
    repeat (2) @(negedge clk);
    expect_now("R11 reset enables");
    s_ab = 1'b1; s_ba = 1'b1; a_in = 8'h5A; b_in = 8'hC3; #1;
    expect_now("R11 reset registers");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    expect_now("R11 registers zero after reset");

    // R5 R6 R7 R8 R12: every mode combination, several patterns
    store(1'b1, 1'b1, 8'hA5, 8'h3C);
    for (int p = 0; p < 3; p++) begin
      for (int m = 0; m < 16; m++) begin
        set_mode(m[3], m[2], m[1], m[0]);
        a_in = 8'h11 * (p + 1) ^ 8'h80; b_in = 8'h0F << p;
        #1;
        expect_now("R5 R6 R7 R8 mode table");
      end
    end

    // R12: select flip shows in the same cycle
    set_mode(1'b0, 1'b1, 1'b0, 1'b0);
    #1; expect_now("R12 live");
    s_ab = 1'b1; #1; expect_now("R12 select to stored same cycle");

    // R4: store during isolation, then transfer stored data
    set_mode(1'b1, 1'b0, 1'b1, 1'b1);
    store(1'b1, 1'b0, 8'h96, 8'h00);
    a_in = 8'hFF; #1;
    expect_now("R4 R1 isolated A store");
    store(1'b0, 1'b1, 8'h00, 8'h69);
    b_in = 8'h00; #1;
    expect_now("R4 R2 isolated B store");
    set_mode(1'b0, 1'b1, 1'b1, 1'b0);
    #1; expect_now("R4 R7 stored A to B");
    set_mode(1'b0, 1'b0, 1'b0, 1'b1);
    #1; expect_now("R4 R8 stored B to A");

    // R10: both strobes together
    store(1'b1, 1'b1, 8'h12, 8'hED);
    set_mode(1'b0, 1'b1, 1'b1, 1'b1);
    a_in = 8'h00; b_in = 8'h00; #1;
    expect_now("R10 dual load");

    // R3: strobe held high, bus changes, no reload
    @(negedge clk); a_in = 8'h77; a_stb = 1'b1;
    @(posedge clk); ref_a = 8'h77;
    @(negedge clk); a_in = 8'h22;
    repeat (3) @(negedge clk);
    a_in = 8'h44; #1;
    expect_now("R3 strobe held high");
    a_stb = 1'b0;
    repeat (2) @(negedge clk);
    a_in = 8'h99; #1;
    expect_now("R3 strobe low");

    // R1: capture of the receiving bus while it is driven through
    set_mode(1'b0, 1'b1, 1'b0, 1'b1);
    store(1'b1, 1'b0, 8'h3E, 8'h00);
    s_ab = 1'b1; a_in = 8'h01; #1;
    expect_now("R1 capture while passing live");

    // R9: scan for simultaneous enables
    for (int m = 0; m < 4; m++) begin
      set_mode(m[1], m[0], 1'b0, 1'b0);
      #1;
      checks++;
      if (a_oe && b_oe) begin
        errors++;
        $display("FAIL R9: a_oe=%b b_oe=%b expected not both 1", a_oe, b_oe);
      end
    end

    wait (sb_q.size() == 0);
    #2;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule